// File: doc/BRIEF.md
# Even/Odd Interleaved Dual-Bank Request Router

The router takes up to two doubleword memory requests per clock, one on each request port. Each request is a load or a store to a doubleword address. The low address bit picks one of two single-ported banks. Even doubleword addresses go to bank 0 and odd ones to bank 1, so a stream of consecutive doublewords alternates between the banks. When the two ports hit different banks, both requests go through in the same cycle. When they hit the same bank, port 0 takes the bank and port 1 sees a stall for that cycle.

Every bank access goes through a fixed five-stage pipeline. The stages are request capture, array read or write, and three delay stages. A bank can start a new access every cycle, so load data streams out with no bubbles. Store data comes in on the request write-data buses and load data goes out on separate response buses, so a bank can alternate stores and loads with no idle cycle between them.

Each store carries four parity bits, one for each 16-bit slice, and they are written next to the data. On a load, the router recomputes parity from the data it read and compares it with the stored bits. A mismatch shows up as a per-slice error flag on the response of the port that issued the load.

Top module: `dual_bank_router`

## Requirements
- R1: The bank is chosen by address bit 0. If bit 0 is 0 the request goes to bank 0, and if it is 1 the request goes to bank 1. Two valid requests conflict exactly when their bit 0 values are equal.
- R2: Two valid requests that target different banks are both accepted in the same cycle, and neither port is stalled.
- R3: On a conflict, port 0's request is performed, `req1_stall` is high for that cycle, and port 1's request is dropped. A dropped store does not write, and a dropped load produces no response.
- R4: A cycle may carry two loads, two stores, or one load and one store, in any assignment to the two ports.
- R5: A load sampled at clock edge N is returned after edge N+4 (five edges, counting N). Load data is never returned earlier or later than that.
- R6: Load responses appear on the outputs of the port that issued the load. Loads issued on consecutive cycles return on consecutive cycles in issue order, with no gaps.
- R7: A store writes its 64-bit data and its 4 parity bits. Parity bit i belongs to data bits [16i+15:16i]. A store produces no response.
- R8: A load response's error flag bit i is set when the stored parity bit i differs from the XOR of slice i of the returned data (even parity). When the response valid is low, all error flag bits are zero.
- R9: On one bank, a store in one cycle followed by a load to the same address in the next cycle returns the new data. Stores and loads can alternate every cycle with no idle cycle.
- R10: After reset, neither response valid is asserted until a load has been performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req0_valid | input | 1 | Port 0 request present |
| req0_store | input | 1 | Port 0 request is a store (1) or a load (0) |
| req0_addr | input | ADDR_W | Port 0 doubleword address |
| req0_wdata | input | 64 | Port 0 store data |
| req0_wpar | input | 4 | Port 0 store parity, one bit per 16-bit slice |
| req1_valid | input | 1 | Port 1 request present |
| req1_store | input | 1 | Port 1 request is a store (1) or a load (0) |
| req1_addr | input | ADDR_W | Port 1 doubleword address |
| req1_wdata | input | 64 | Port 1 store data |
| req1_wpar | input | 4 | Port 1 store parity, one bit per 16-bit slice |
| req1_stall | output | 1 | Port 1 request lost a bank conflict this cycle |
| rsp0_valid | output | 1 | Load response for port 0 |
| rsp0_data | output | 64 | Port 0 load data |
| rsp0_perr | output | 4 | Port 0 per-slice parity error flags |
| rsp1_valid | output | 1 | Load response for port 1 |
| rsp1_data | output | 64 | Port 1 load data |
| rsp1_perr | output | 4 | Port 1 per-slice parity error flags |

## Verification
The assertions rely on two conditions. First, each request port presents at most one request per cycle. Second, every bank path has the same fixed depth, so two banks can never return data to the same port in one cycle. The stimulus drives each port with a single request at a time and holds it for exactly one cycle. It reads back only addresses it has already written, so no load returns undefined contents. The tests that force parity errors corrupt the parity bits supplied with a store and leave the data unchanged, so the error flags can be predicted directly from the injected flips.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

  parameter int unsigned DW      = 64;
  parameter int unsigned SLICE_W = 16;
  parameter int unsigned NSLICE  = DW / SLICE_W;
  parameter int unsigned ADDR_W  = 8;

  typedef struct packed {
    logic              valid;
    logic              port;
    logic [NSLICE-1:0] par;
    logic [DW-1:0]     data;
  } bank_rsp_t;

  // even parity bit per slice: XOR of the slice's bits
  function automatic logic [NSLICE-1:0] slice_parity(input logic [DW-1:0] d);
    logic [NSLICE-1:0] p;
    for (int s = 0; s < NSLICE; s++) begin
      p[s] = ^d[s*SLICE_W +: SLICE_W];
    end
    return p;
  endfunction

  // bank index from doubleword address low bit
  function automatic logic bank_of(input logic lsb);
    return lsb;
  endfunction

endpackage

// File: rtl/rtr_steer.sv
module rtr_steer
  import rtr_pkg::*;
#(
  parameter int unsigned ADDR_W = rtr_pkg::ADDR_W,
  localparam int unsigned IW    = ADDR_W - 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        v0,
  input  logic                        st0,
  input  logic [ADDR_W-1:0]           a0,
  input  logic [DW-1:0]               d0,
  input  logic [NSLICE-1:0]           p0,
  input  logic                        v1,
  input  logic                        st1,
  input  logic [ADDR_W-1:0]           a1,
  input  logic [DW-1:0]               d1,
  input  logic [NSLICE-1:0]           p1,
  output logic                        p1_stall,
  output logic [1:0]                  bk_go,
  output logic [1:0]                  bk_st,
  output logic [1:0]                  bk_port,
  output logic [1:0][IW-1:0]          bk_idx,
  output logic [1:0][DW-1:0]          bk_wd,
  output logic [1:0][NSLICE-1:0]      bk_wp
);

  logic tgt0, tgt1, clash, grant1;

  always_comb begin
    tgt0   = bank_of(a0[0]);
    tgt1   = bank_of(a1[0]);
    clash  = v0 && v1 && (tgt0 == tgt1);
    grant1 = v1 && !clash;
  end

  assign p1_stall = clash;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic sel0, sel1;
    always_comb begin
      sel0       = v0 && (tgt0 == 1'(b));
      sel1       = grant1 && (tgt1 == 1'(b));
      bk_go[b]   = sel0 || sel1;
      bk_port[b] = sel1;
      bk_st[b]   = sel1 ? st1 : st0;
      bk_idx[b]  = sel1 ? a1[ADDR_W-1:1] : a0[ADDR_W-1:1];
      bk_wd[b]   = sel1 ? d1 : d0;
      bk_wp[b]   = sel1 ? p1 : p0;
    end
  end

  // R1: a port-0 request on the odd bank must carry an odd address
  assert_odd_bank_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_go[1] && !bk_port[1]) |-> a0[0]);

  // R3: on a stall the contested bank serves port 0
  assert_stall_port0_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    p1_stall |-> (bk_go[a1[0]] && !bk_port[a1[0]] && v0));

endmodule

// File: rtl/rtr_bank.sv
module rtr_bank
  import rtr_pkg::*;
#(
  parameter int unsigned IW  = rtr_pkg::ADDR_W - 1,
  parameter int unsigned LAT = 5,
  localparam int unsigned DEPTH = 1 << IW,
  localparam int unsigned NDLY  = LAT - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              st,
  input  logic              port,
  input  logic [IW-1:0]     idx,
  input  logic [DW-1:0]     wd,
  input  logic [NSLICE-1:0] wp,
  output bank_rsp_t         rsp
);

  // stage 1: capture
  logic              s1_go, s1_st, s1_port;
  logic [IW-1:0]     s1_idx;
  logic [DW-1:0]     s1_wd;
  logic [NSLICE-1:0] s1_wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_go   <= 1'b0;
      s1_st   <= 1'b0;
      s1_port <= 1'b0;
      s1_idx  <= '0;
      s1_wd   <= '0;
      s1_wp   <= '0;
    end else begin
      s1_go   <= go;
      s1_st   <= st;
      s1_port <= port;
      s1_idx  <= idx;
      s1_wd   <= wd;
      s1_wp   <= wp;
    end
  end

  // stage 2: array access, single port
  logic [NSLICE+DW-1:0] mem [DEPTH];
  logic                 do_wr, do_rd;

  assign do_wr = s1_go && s1_st;
  assign do_rd = s1_go && !s1_st;

  always_ff @(posedge clk) begin
    if (do_wr) mem[s1_idx] <= {s1_wp, s1_wd};
  end

  bank_rsp_t pipe [NDLY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe[0] <= '0;
    end else begin
      pipe[0].valid <= do_rd;
      pipe[0].port  <= s1_port;
      if (do_rd) {pipe[0].par, pipe[0].data} <= mem[s1_idx];
    end
  end

  // stages 3..LAT: delay
  for (genvar k = 1; k < NDLY; k++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[k] <= '0;
      else        pipe[k] <= pipe[k-1];
    end
  end

  assign rsp = pipe[NDLY-1];

  // R7: a store never yields a response out of the array stage
  assert_store_no_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |=> !pipe[0].valid);

endmodule

// File: rtl/rtr_merge.sv
module rtr_merge
  import rtr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  bank_rsp_t              rsp_b0,
  input  bank_rsp_t              rsp_b1,
  output logic [1:0]             pv,
  output logic [1:0][DW-1:0]     pd,
  output logic [1:0][NSLICE-1:0] pe
);

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic hit0, hit1;
    bank_rsp_t pick;
    always_comb begin
      hit0  = rsp_b0.valid && (rsp_b0.port == 1'(p));
      hit1  = rsp_b1.valid && (rsp_b1.port == 1'(p));
      pick  = hit1 ? rsp_b1 : rsp_b0;
      pv[p] = hit0 || hit1;
      pd[p] = pick.data;
      pe[p] = pv[p] ? (slice_parity(pick.data) ^ pick.par) : '0;
    end

    // R6: equal bank depths mean at most one bank answers a port per cycle
    assert_one_rsp_per_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit0 && hit1));
  end

endmodule

// File: rtl/dual_bank_router.sv
module dual_bank_router
  import rtr_pkg::*;
#(
  parameter int unsigned ADDR_W = rtr_pkg::ADDR_W,
  parameter int unsigned LAT    = 5,
  localparam int unsigned IW    = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req0_valid,
  input  logic              req0_store,
  input  logic [ADDR_W-1:0] req0_addr,
  input  logic [63:0]       req0_wdata,
  input  logic [3:0]        req0_wpar,
  input  logic              req1_valid,
  input  logic              req1_store,
  input  logic [ADDR_W-1:0] req1_addr,
  input  logic [63:0]       req1_wdata,
  input  logic [3:0]        req1_wpar,
  output logic              req1_stall,
  output logic              rsp0_valid,
  output logic [63:0]       rsp0_data,
  output logic [3:0]        rsp0_perr,
  output logic              rsp1_valid,
  output logic [63:0]       rsp1_data,
  output logic [3:0]        rsp1_perr
);

  logic [1:0]             bk_go, bk_st, bk_port;
  logic [1:0][IW-1:0]     bk_idx;
  logic [1:0][DW-1:0]     bk_wd;
  logic [1:0][NSLICE-1:0] bk_wp;
  bank_rsp_t              bk_rsp [2];

  rtr_steer #(.ADDR_W(ADDR_W)) u_steer (
    .clk(clk), .rst_n(rst_n),
    .v0(req0_valid), .st0(req0_store), .a0(req0_addr), .d0(req0_wdata), .p0(req0_wpar),
    .v1(req1_valid), .st1(req1_store), .a1(req1_addr), .d1(req1_wdata), .p1(req1_wpar),
    .p1_stall(req1_stall),
    .bk_go(bk_go), .bk_st(bk_st), .bk_port(bk_port),
    .bk_idx(bk_idx), .bk_wd(bk_wd), .bk_wp(bk_wp)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    rtr_bank #(.IW(IW), .LAT(LAT)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .go(bk_go[b]), .st(bk_st[b]), .port(bk_port[b]),
      .idx(bk_idx[b]), .wd(bk_wd[b]), .wp(bk_wp[b]),
      .rsp(bk_rsp[b])
    );
  end

  logic [1:0]             pv;
  logic [1:0][DW-1:0]     pd;
  logic [1:0][NSLICE-1:0] pe;

  rtr_merge u_merge (
    .clk(clk), .rst_n(rst_n),
    .rsp_b0(bk_rsp[0]), .rsp_b1(bk_rsp[1]),
    .pv(pv), .pd(pd), .pe(pe)
  );

  assign rsp0_valid = pv[0];
  assign rsp0_data  = pd[0];
  assign rsp0_perr  = pe[0];
  assign rsp1_valid = pv[1];
  assign rsp1_data  = pd[1];
  assign rsp1_perr  = pe[1];

  // R8: error flags are quiet when no response is presented
  assert_perr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp0_valid |-> rsp0_perr == '0) and (!rsp1_valid |-> rsp1_perr == '0));

endmodule

// File: tb/test_dual_bank_router.sv
`timescale 1ns/1ps
module test_dual_bank_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req0_valid = 0, req0_store = 0;
  logic [7:0]  req0_addr = 0;
  logic [63:0] req0_wdata = 0;
  logic [3:0]  req0_wpar = 0;
  logic        req1_valid = 0, req1_store = 0;
  logic [7:0]  req1_addr = 0;
  logic [63:0] req1_wdata = 0;
  logic [3:0]  req1_wpar = 0;
  logic        req1_stall;
  logic        rsp0_valid, rsp1_valid;
  logic [63:0] rsp0_data, rsp1_data;
  logic [3:0]  rsp0_perr, rsp1_perr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_bank_router i_dual_bank_router (.*);

  always #10 clk = ~clk;

  // log of outputs, taken 2 ns after every rising edge
  int          cyc = 0;
  logic        lv0 [256], lv1 [256];
  logic [63:0] ld0 [256], ld1 [256];
  logic [3:0]  le0 [256], le1 [256];

  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    lv0[cyc % 256] = rsp0_valid; ld0[cyc % 256] = rsp0_data; le0[cyc % 256] = rsp0_perr;
    lv1[cyc % 256] = rsp1_valid; ld1[cyc % 256] = rsp1_data; le1[cyc % 256] = rsp1_perr;
  end

  function automatic logic [3:0] gpar(input logic [63:0] d);
    logic [3:0] r = '0;
    for (int s = 0; s < 4; s++) begin
      int n = 0;
      for (int b = 0; b < 16; b++) n += int'(d[16*s+b]);
      r[s] = (n % 2) == 1;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drv0(input logic v, input logic s, input logic [7:0] a,
                      input logic [63:0] d, input logic [3:0] flip);
    req0_valid = v; req0_store = s; req0_addr = a; req0_wdata = d;
    req0_wpar = gpar(d) ^ flip;
  endtask

  task automatic drv1(input logic v, input logic s, input logic [7:0] a,
                      input logic [63:0] d, input logic [3:0] flip);
    req1_valid = v; req1_store = s; req1_addr = a; req1_wdata = d;
    req1_wpar = gpar(d) ^ flip;
  endtask

  task automatic idle();
    drv0(0, 0, 0, 0, 0); drv1(0, 0, 0, 0, 0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    idle();
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic logic [63:0] val(input int a);
    return {32'hA5C3_0000 | 32'(a), 32'(a) * 32'h9E37_79B1};
  endfunction

  // R10: quiet after reset
  task automatic t_reset();
    chk("R10 rsp0_valid after reset", 64'(rsp0_valid), 0);
    chk("R10 rsp1_valid after reset", 64'(rsp1_valid), 0);
  endtask

  // R1, R2, R4, R5, R7: opposite-bank stores and loads
  task automatic t_basic();
    int c;
    drv0(1, 1, 8'd10, val(10), 0); drv1(1, 1, 8'd11, val(11), 0);
    #1 chk("R2 no stall even/odd stores", 64'(req1_stall), 0);
    step();
    drv0(1, 1, 8'd13, val(13), 0); drv1(1, 1, 8'd12, val(12), 0);
    #1 chk("R2 no stall odd/even stores", 64'(req1_stall), 0);
    step();
    c = cyc;
    drv0(1, 0, 8'd11, 0, 0); drv1(1, 0, 8'd10, 0, 0);
    #1 chk("R4 two loads no stall", 64'(req1_stall), 0);
    step();
    wait_n(7);
    chk("R5 port0 not early", 64'(lv0[(c+4) % 256]), 0);
    chk("R5 port0 valid at five edges", 64'(lv0[(c+5) % 256]), 1);
    chk("R1 port0 odd data", ld0[(c+5) % 256], val(11));
    chk("R7 port0 perr clean", 64'(le0[(c+5) % 256]), 0);
    chk("R5 port1 valid at five edges", 64'(lv1[(c+5) % 256]), 1);
    chk("R1 port1 even data", ld1[(c+5) % 256], val(10));
    chk("R5 port0 single beat", 64'(lv0[(c+6) % 256]), 0);
  endtask

  // R1, R3: conflict detection and port-0 priority
  task automatic t_conflict();
    int c1, c2, c3;
    drv0(1, 0, 8'd20, 0, 0); drv1(1, 0, 8'd22, 0, 0);
    #1 chk("R1 even/even conflicts", 64'(req1_stall), 1);
    drv1(1, 0, 8'd23, 0, 0);
    #1 chk("R1 even/odd free", 64'(req1_stall), 0);
    drv0(1, 0, 8'd21, 0, 0);
    #1 chk("R1 odd/odd conflicts", 64'(req1_stall), 1);
    idle();
    #1 chk("R1 idle no stall", 64'(req1_stall), 0);
    drv0(1, 1, 8'd14, val(14), 0); drv1(1, 1, 8'd12, 64'hDEAD_BEEF_0BAD_F00D, 0);
    #1 chk("R3 store conflict stalls port1", 64'(req1_stall), 1);
    step();
    c3 = cyc;
    drv0(1, 0, 8'd13, 0, 0); drv1(1, 0, 8'd11, 0, 0);
    #1 chk("R3 load conflict stalls port1", 64'(req1_stall), 1);
    step();
    c1 = cyc;
    drv0(1, 0, 8'd12, 0, 0);
    step();
    c2 = cyc;
    drv0(1, 0, 8'd14, 0, 0);
    step();
    wait_n(7);
    chk("R3 winner load returns", ld0[(c3+5) % 256], val(13));
    chk("R3 dropped load no response", 64'(lv1[(c3+5) % 256]), 0);
    chk("R3 dropped store did not write", ld0[(c1+5) % 256], val(12));
    chk("R3 winner store written", ld0[(c2+5) % 256], val(14));
  endtask

  // R5, R6: back-to-back streams on both ports
  task automatic t_stream();
    int c;
    for (int i = 0; i < 5; i++) begin
      drv0(1, 1, 8'(32 + 2*i), val(32 + 2*i), 0);
      drv1(1, 1, 8'(33 + 2*i), val(33 + 2*i), 0);
      step();
    end
    c = cyc;
    for (int i = 0; i < 5; i++) begin
      drv0(1, 0, 8'(32 + 2*i), 0, 0);
      drv1(1, 0, 8'(41 - 2*i), 0, 0);
      step();
    end
    wait_n(7);
    for (int i = 0; i < 5; i++) begin
      chk("R6 stream port0 valid", 64'(lv0[(c+5+i) % 256]), 1);
      chk("R6 stream port0 order", ld0[(c+5+i) % 256], val(32 + 2*i));
      chk("R6 stream port1 valid", 64'(lv1[(c+5+i) % 256]), 1);
      chk("R6 stream port1 order", ld1[(c+5+i) % 256], val(41 - 2*i));
    end
    chk("R5 stream ends", 64'(lv0[(c+10) % 256]), 0);
  endtask

  // R9, R4: alternating store/load on one bank, mixed load+store
  task automatic t_alternate();
    int c;
    c = cyc;
    drv0(1, 1, 8'd50, 64'h1111_2222_3333_4444, 0); drv1(1, 0, 8'd33, 0, 0);
    #1 chk("R4 store+load no stall", 64'(req1_stall), 0);
    step();
    drv0(1, 0, 8'd50, 0, 0); drv1(0, 0, 0, 0, 0);
    step();
    drv0(1, 1, 8'd50, 64'h5555_6666_7777_8888, 0);
    step();
    drv0(1, 0, 8'd50, 0, 0);
    step();
    wait_n(8);
    chk("R4 mixed load returns", ld1[(c+5) % 256], val(33));
    chk("R9 first load sees store", ld0[(c+6) % 256], 64'h1111_2222_3333_4444);
    chk("R9 second load valid", 64'(lv0[(c+8) % 256]), 1);
    chk("R9 second load sees store", ld0[(c+8) % 256], 64'h5555_6666_7777_8888);
  endtask

  // R8: injected parity faults
  task automatic t_parity();
    int c;
    drv0(1, 1, 8'd60, 64'hFEDC_BA98_7654_3210, 4'b0100);
    drv1(1, 1, 8'd61, 64'h0F0F_F0F0_1234_ABCD, 4'b1001);
    step();
    c = cyc;
    drv0(1, 0, 8'd60, 0, 0); drv1(1, 0, 8'd61, 0, 0);
    step();
    wait_n(7);
    chk("R8 port0 perr slice 2", 64'(le0[(c+5) % 256]), 64'(4'b0100));
    chk("R8 port0 data intact", ld0[(c+5) % 256], 64'hFEDC_BA98_7654_3210);
    chk("R8 port1 perr slices 0,3", 64'(le1[(c+5) % 256]), 64'(4'b1001));
    chk("R8 perr zero when idle", 64'(le0[(c+6) % 256]), 0);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_conflict();
    t_stream();
    t_alternate();
    t_parity();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule